// File: doc/BRIEF.md
# Single-Bus ALU Datapath Stage

This block is the arithmetic section of a processor whose registers all share one internal bus. A staging register (Y) takes a value from the bus, and a 2:1 selector feeds the ALU's first operand with either that staged value or the fixed constant 4. The second operand always comes from the bus. A combinational ALU, chosen by a 4-bit function code and a carry-in, produces a result that is captured in a result register (Z). Z, when enabled, is the value placed on the bus.

A two-operand operation takes three clock cycles. In the first, the first source is on the bus and Y loads. In the second, the second source is on the bus and Z loads the ALU result. In the third, Z drives the bus so that a destination register outside this block can take it. The bus is modelled without tri-states. `bus_in` is the value any other driver presents, and `ext_drive` says whether one is driving. The resolved bus value is output on `bus_q` and is also what the ALU sees on its second operand. The data path is made of control strobes rather than a stream, so there is no valid/ready handshake. The pins are plain and take effect on the clock edge at which they are sampled.

Top module: `alu_stage`

## Requirements
- R1: A synchronous active-high `rst` clears Y and Z to zero on the next rising edge.
- R2: ALU operand A equals Y when `sel_y` is 1 and equals the constant 4 when `sel_y` is 0.
- R3: Y loads the resolved bus value on a rising edge where `y_load` is 1, and it holds its value otherwise.
- R4: Z loads the ALU result, never the bus, on a rising edge where `z_load` is 1, and it holds its value otherwise.
- R5: ALU operand B is the resolved bus value. When Z drives the bus, B therefore equals Z.
- R6: `bus_q` equals Z while `z_drive` is 1, and equals `bus_in` otherwise.
- R7: The arithmetic codes are computed modulo 2^W. Code 0 gives A+B+cin, 1 gives A+B+1, 2 gives A-B, 3 gives A+~B+cin (A-B-1 when cin is 0), 8 gives ~A+1 and 9 gives ~B+1.
- R8: The logic codes are: 4 gives A&B, 5 gives A|B, 6 gives ~A, 7 gives ~B, 10 gives ~A&B, 11 gives A&~B, 12 gives A^B, 13 gives ~(A^B), 14 passes A and 15 passes B.
- R9: When sources X and then Yv are presented in consecutive cycles with the strobes of the three-cycle sequence, the third cycle shows X op Yv on `bus_q`.
- R10: `z_drive` and `ext_drive` are never both 1 in the same cycle. A bus conflict is flagged as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | W | Value presented by the other bus driver |
| ext_drive | input | 1 | Another driver owns the bus this cycle |
| y_load | input | 1 | Load Y from the bus |
| z_load | input | 1 | Load Z from the ALU result |
| z_drive | input | 1 | Place Z on the bus |
| sel_y | input | 1 | 1: operand A is Y, 0: operand A is 4 |
| func | input | 4 | ALU function code |
| carry_in | input | 1 | Carry into codes 0 and 3 |
| bus_q | output | W | Resolved bus value |

## Verification
The hardest case to reach is the feedback loop where Z drives the bus and loads in the same cycle. In that loop, operand B is the old Z and the new Z depends on it. The stimulus sets up Y and Z through ordinary sequences and then asserts `z_drive` and `z_load` together under pass-B and add codes. All sixteen codes are then run through the full three-cycle sequence with operands that wrap around, and the constant-4 path is checked the same way.

// File: rtl/alu_stage_pkg.sv
package alu_stage_pkg;
  typedef enum logic [3:0] {
    FN_ADD    = 4'd0,
    FN_ADD1   = 4'd1,
    FN_SUB    = 4'd2,
    FN_SUBC   = 4'd3,
    FN_AND    = 4'd4,
    FN_OR     = 4'd5,
    FN_NOTA   = 4'd6,
    FN_NOTB   = 4'd7,
    FN_NEGA   = 4'd8,
    FN_NEGB   = 4'd9,
    FN_NAANDB = 4'd10,
    FN_AANDNB = 4'd11,
    FN_XOR    = 4'd12,
    FN_XNOR   = 4'd13,
    FN_PASSA  = 4'd14,
    FN_PASSB  = 4'd15
  } alu_fn_e;
endpackage

// File: rtl/alu_stage_reg.sv
module alu_stage_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/alu_stage_opmux.sv
module alu_stage_opmux #(
  parameter int W     = 32,
  parameter int CONST = 4
) (
  input  logic         sel_y,
  input  logic [W-1:0] y_val,
  output logic [W-1:0] opnd
);
  localparam logic [W-1:0] CONST_V = W'(CONST);
  always_comb opnd = sel_y ? y_val : CONST_V;
endmodule

// File: rtl/alu_stage_alu.sv
module alu_stage_alu
  import alu_stage_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   func,
  input  logic         cin,
  output logic [W-1:0] f
);
  logic [W-1:0] add_x, add_y, sum;
  logic         add_c;
  alu_fn_e      fn;

  always_comb fn = alu_fn_e'(func);

  // shared adder operand steering
  always_comb begin
    add_x = a;
    add_y = b;
    add_c = 1'b0;
    unique case (fn)
      FN_ADD:  add_c = cin;
      FN_ADD1: add_c = 1'b1;
      FN_SUB:  begin add_y = ~b; add_c = 1'b1; end
      FN_SUBC: begin add_y = ~b; add_c = cin;  end
      FN_NEGA: begin add_x = ~a; add_y = '0; add_c = 1'b1; end
      FN_NEGB: begin add_x = ~b; add_y = '0; add_c = 1'b1; end
      default: ;
    endcase
  end

  always_comb sum = add_x + add_y + {{(W-1){1'b0}}, add_c};

  always_comb begin
    unique case (fn)
      FN_ADD, FN_ADD1, FN_SUB, FN_SUBC,
      FN_NEGA, FN_NEGB: f = sum;
      FN_AND:    f = a & b;
      FN_OR:     f = a | b;
      FN_NOTA:   f = ~a;
      FN_NOTB:   f = ~b;
      FN_NAANDB: f = ~a & b;
      FN_AANDNB: f = a & ~b;
      FN_XOR:    f = a ^ b;
      FN_XNOR:   f = ~(a ^ b);
      FN_PASSA:  f = a;
      FN_PASSB:  f = b;
      default:   f = '0;
    endcase
  end
endmodule

// File: rtl/alu_stage.sv
module alu_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bus_in,
  input  logic         ext_drive,
  input  logic         y_load,
  input  logic         z_load,
  input  logic         z_drive,
  input  logic         sel_y,
  input  logic [3:0]   func,
  input  logic         carry_in,
  output logic [W-1:0] bus_q
);
  logic [W-1:0] y_q, z_q, opnd_a, alu_f;

  // resolved bus: Z when enabled, otherwise the other driver
  always_comb bus_q = z_drive ? z_q : bus_in;

  alu_stage_reg #(.W(W)) y_reg_i (
    .clk(clk), .rst(rst), .load(y_load), .d(bus_q), .q(y_q)
  );

  alu_stage_opmux #(.W(W), .CONST(4)) opmux_i (
    .sel_y(sel_y), .y_val(y_q), .opnd(opnd_a)
  );

  alu_stage_alu #(.W(W)) alu_i (
    .a(opnd_a), .b(bus_q), .func(func), .cin(carry_in), .f(alu_f)
  );

  alu_stage_reg #(.W(W)) z_reg_i (
    .clk(clk), .rst(rst), .load(z_load), .d(alu_f), .q(z_q)
  );
endmodule

// File: rtl/alu_stage_chk.sv
module alu_stage_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         y_load,
  input logic         z_load,
  input logic         z_drive,
  input logic         ext_drive,
  input logic         sel_y,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_q,
  input logic [W-1:0] y_q,
  input logic [W-1:0] z_q,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] alu_f
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (y_q == '0 && z_q == '0)); // R1
  AST_OPND_CONST: assert property (@(posedge clk) disable iff (rst) !sel_y |-> opnd_a == W'(4)); // R2
  AST_OPND_Y: assert property (@(posedge clk) disable iff (rst) sel_y |-> opnd_a == y_q); // R2
  AST_Y_LOADS: assert property (@(posedge clk) disable iff (rst) y_load |=> y_q == $past(bus_q)); // R3
  AST_Y_HOLDS: assert property (@(posedge clk) disable iff (rst) !y_load |=> $stable(y_q)); // R3
  AST_Z_LOADS: assert property (@(posedge clk) disable iff (rst) z_load |=> z_q == $past(alu_f)); // R4
  AST_Z_HOLDS: assert property (@(posedge clk) disable iff (rst) !z_load |=> $stable(z_q)); // R4
  AST_BUS_FROM_Z: assert property (@(posedge clk) disable iff (rst) z_drive |-> bus_q == z_q); // R6
  AST_BUS_FROM_EXT: assert property (@(posedge clk) disable iff (rst) !z_drive |-> bus_q == bus_in); // R6
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst) !(z_drive && ext_drive)); // R10
endmodule

bind alu_stage alu_stage_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .y_load(y_load), .z_load(z_load), .z_drive(z_drive),
  .ext_drive(ext_drive), .sel_y(sel_y), .bus_in(bus_in), .bus_q(bus_q),
  .y_q(y_q), .z_q(z_q), .opnd_a(opnd_a), .alu_f(alu_f)
);

// File: tb/alu_stage_tb_top.sv
module alu_stage_tb_top;
  localparam int W = 32;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] bus_in = '0;
  logic         ext_drive = 1'b0, y_load = 1'b0, z_load = 1'b0, z_drive = 1'b0;
  logic         sel_y = 1'b1, carry_in = 1'b0;
  logic [3:0]   func = 4'd0;
  logic [W-1:0] bus_q;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [W-1:0] m_y = '0, m_z = '0;

  always #10 clk = ~clk;

  alu_stage #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .bus_in(bus_in), .ext_drive(ext_drive),
    .y_load(y_load), .z_load(z_load), .z_drive(z_drive), .sel_y(sel_y),
    .func(func), .carry_in(carry_in), .bus_q(bus_q)
  );

  function automatic logic [W-1:0] ref_op(input int code, input logic [W-1:0] a,
                                          input logic [W-1:0] b, input logic c);
    case (code)
      0: return a + b + W'(c);
      1: return a + b + 1;
      2: return a - b;
      3: return a - b - 1 + W'(c);
      4: return a & b;
      5: return a | b;
      6: return ~a;
      7: return ~b;
      8: return 0 - a;
      9: return 0 - b;
      10: return (~a) & b;
      11: return a & (~b);
      12: return a ^ b;
      13: return ~(a ^ b);
      14: return a;
      default: return b;
    endcase
  endfunction

  // one clock: drive inputs, compare the bus, advance the model
  task automatic step(input string tag, input logic [W-1:0] din, input logic ext,
                      input logic yl, input logic zl, input logic zd,
                      input logic sy, input int fn, input logic c);
    logic [W-1:0] exp_bus, a;
    bus_in = din; ext_drive = ext; y_load = yl; z_load = zl; z_drive = zd;
    sel_y = sy; func = 4'(fn); carry_in = c;
    #5;
    exp_bus = zd ? m_z : din;
    n_chk++;
    if (bus_q !== exp_bus) begin
      n_fail++;
      $display("FAIL %s: bus_q=%h expected %h", tag, bus_q, exp_bus);
    end
    @(posedge clk);
    a = sy ? m_y : W'(4);
    if (rst) begin m_y = '0; m_z = '0; end
    else begin
      if (zl) m_z = ref_op(fn, a, exp_bus, c);
      if (yl) m_y = exp_bus;
    end
    @(negedge clk);
  endtask

  task automatic seq3(input string tag, input logic [W-1:0] x, input logic [W-1:0] v,
                      input int fn, input logic c, input logic sy);
    step(tag, x, 1, 1, 0, 0, 1, 0, 0);
    step(tag, v, 1, 0, 1, 0, sy, fn, c);
    step(tag, '0, 0, 0, 0, 1, 1, 0, 0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] xs[4] = '{32'h0000_0005, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678};
    logic [W-1:0] vs[4] = '{32'h0000_0003, 32'h0000_0001, 32'h8000_0001, 32'h0F0F_F0F0};
    @(negedge clk);
    step("R1", 32'hAAAA_AAAA, 1, 1, 1, 0, 1, 0, 0);
    rst = 1'b0;
    step("R1", '0, 0, 0, 0, 1, 1, 0, 0);              // Z reads zero after reset
    step("R1", '0, 0, 0, 1, 1, 1, 14, 0);              // pass A: Y is zero
    step("R1", '0, 0, 0, 0, 1, 1, 0, 0);
    // every code on several operand pairs (R7 arithmetic, R8 logic, R9 sequence)
    for (int f = 0; f < 16; f++)
      for (int k = 0; k < 4; k++) begin
        seq3((f < 4 || f == 8 || f == 9) ? "R7" : "R8", xs[k], vs[k], f, 1'b0, 1'b1);
        if (f == 0 || f == 3) seq3("R7", xs[k], vs[k], f, 1'b1, 1'b1);
      end
    seq3("R9", 32'd100, 32'd23, 0, 1'b0, 1'b1);
    // constant-4 operand
    seq3("R2", 32'hDEAD_BEEF, 32'd10, 0, 1'b0, 1'b0);
    seq3("R2", 32'hDEAD_BEEF, 32'd0, 14, 1'b0, 1'b0);
    // holds: no strobes, Z stays, Y stays
    step("R4", 32'h5555_5555, 1, 0, 0, 0, 1, 0, 0);
    step("R4", '0, 0, 0, 0, 1, 1, 0, 0);
    step("R3", '0, 0, 0, 1, 1, 1, 14, 0);              // Y still DEADBEEF
    step("R3", '0, 0, 0, 0, 1, 1, 0, 0);
    // Z feeding back as operand B
    seq3("R5", 32'd7, 32'd9, 0, 1'b0, 1'b1);
    step("R5", '0, 0, 0, 1, 1, 1, 0, 0);               // Z = Y + Z
    step("R5", '0, 0, 0, 1, 1, 1, 15, 0);              // Z = Z
    step("R5", '0, 0, 1, 0, 1, 1, 0, 0);               // Y from Z
    step("R6", 32'h0BAD_F00D, 1, 0, 0, 0, 1, 0, 0);
    step("R10", '0, 0, 0, 1, 1, 1, 14, 0);
    step("R10", '0, 0, 0, 0, 1, 1, 0, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule